// File: doc/BRIEF.md
# Dequantize, Inverse Transform and Reconstruct Unit

This unit turns one 4x4 block of quantized residual coefficients back into pixels. A single start pulse captures sixteen signed coefficients, sixteen dequantization factors and sixteen 8-bit predictor pixels. The unit then scales each coefficient by its factor. It runs a two-pass fixed-point inverse transform, first down the columns and then along the rows. It rounds the result, adds it to the predictor and clamps the sum into the 8-bit range.

The reconstructed block leaves the unit as a stream of four rows, one row per cycle. A done flag marks the last row. The internal coefficient store is written back as zeros once the block finishes, so the next block starts from a cleared store. Element k of every 16-element bus is row k/4, column k%4, and it sits at bits [k*W +: W].

Top module: `dqr_top`

## Requirements
- R1: After reset, busy_o, pix_valid_o and done_o are all 0.
- R2: A start_i pulse seen while busy_o is 0 is accepted, and busy_o is 1 in the next cycle. Row 0 appears on pix_o with pix_valid_o high in the fourth cycle after the accepting edge. Rows 1, 2 and 3 follow on the next three cycles. Column 0 of each row is in pix_o[7:0] and column 3 is in pix_o[31:24].
- R3: Dequantization keeps the low 16 bits of coefficient times factor for every element. The dequantized store is visible on coef_buf_o two cycles after the accepting edge.
- R4: The transform uses two scaled products. C(x) = x + ((x*20091)>>>16), and S(x) = (x*35468)>>>16.
- R5: The first pass runs down each column c over elements c, c+4, c+8 and c+12. Its outputs wrap to 16-bit two's complement. The second pass runs along each row of the first-pass results.
- R6: In each pass, a=i0+i2, b=i0-i2, c=S(i1)-C(i3) and d=C(i1)+S(i3). The four outputs are a+d, b+c, b-c and a-d, in positions 0 to 3.
- R7: Each second-pass result has 4 added and is shifted right arithmetically by 3. The low 16 bits form the signed residual.
- R8: Each pixel is the predictor plus the signed residual, clamped to 0..255. A zero residual reproduces the predictor.
- R9: coef_buf_o reads all zeros in the cycle done_o is high, and it stays zero afterwards until the next accepted start.
- R10: done_o is high for exactly one cycle, together with row 3.
- R11: A start_i pulse while busy_o is 1 is ignored. The block in flight completes unchanged, and no extra rows are produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse; captures all block inputs when idle |
| coef_i | input | 256 | Sixteen signed 16-bit quantized coefficients |
| dqf_i | input | 256 | Sixteen 16-bit dequantization factors |
| pred_i | input | 128 | Sixteen 8-bit predictor pixels |
| busy_o | output | 1 | A block is in flight |
| pix_valid_o | output | 1 | pix_o carries one reconstructed row |
| pix_o | output | 32 | Four reconstructed 8-bit pixels of the current row |
| done_o | output | 1 | Single-cycle marker on the last row |
| coef_buf_o | output | 256 | Coefficient store contents (raw, dequantized, then cleared) |

## Verification
The assertions assume that start_i is a clean synchronous pulse and that nothing depends on input values outside a start cycle. The bench changes coef_i, dqf_i and pred_i only at falling edges, and holds start_i for exactly one cycle. The assertions also assume that a start arriving during a block must not reload the state machine. The bench therefore fires a deliberate start mid-block with different data and expects the first block's rows unchanged. Coefficient and factor ranges are kept small enough that the bench model's 32-bit products never overflow. Some blocks use full-range values so that the 16-bit wrap and both clamp limits are reached.

// File: rtl/dqr_pkg.sv
package dqr_pkg;
  localparam int COEF_W = 16;
  localparam int PIX_W  = 8;
  localparam int DIM    = 4;
  localparam int K_COS  = 20091;
  localparam int K_SIN  = 35468;
  localparam int K_FRAC = 16;
  localparam int RND_ADD = 4;
  localparam int RND_SH  = 3;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_DEQ  = 2'd1,
    S_COL  = 2'd2,
    S_ROW  = 2'd3
  } dqr_state_t;
endpackage

// File: rtl/dqr_dequant.sv
module dqr_dequant #(
  parameter int CW = dqr_pkg::COEF_W,
  parameter int NE = dqr_pkg::DIM * dqr_pkg::DIM
) (
  input  logic [NE*CW-1:0] coef_i,
  input  logic [NE*CW-1:0] dqf_i,
  output logic [NE*CW-1:0] prod_o
);
  for (genvar k = 0; k < NE; k++) begin : g_lane
    logic [CW-1:0] c_v, f_v, p_v;
    assign c_v = coef_i[k*CW +: CW];
    assign f_v = dqf_i[k*CW +: CW];
    // low CW bits of the product are identical for signed and unsigned operands
    assign p_v = c_v * f_v;
    assign prod_o[k*CW +: CW] = p_v;
  end
endmodule

// File: rtl/dqr_bfly.sv
module dqr_bfly #(
  parameter int W  = dqr_pkg::COEF_W,
  parameter int OW = W + 4
) (
  input  logic [4*W-1:0]  in_i,
  output logic [4*OW-1:0] out_o
);
  import dqr_pkg::*;
  localparam int WW = W + 4;
  localparam int PW = 2*W + 4;

  logic signed [W-1:0]  x0, x1, x2, x3;
  logic signed [PW-1:0] p1c, p1s, p3c, p3s;
  logic signed [WW-1:0] c1v, s1v, c3v, s3v;
  logic signed [WW-1:0] a_v, b_v, c_v, d_v;
  logic signed [WW-1:0] o0, o1, o2, o3;

  always_comb begin
    x0 = $signed(in_i[0*W +: W]);
    x1 = $signed(in_i[1*W +: W]);
    x2 = $signed(in_i[2*W +: W]);
    x3 = $signed(in_i[3*W +: W]);
    p1c = PW'(x1) * $signed(PW'(K_COS));
    p1s = PW'(x1) * $signed(PW'(K_SIN));
    p3c = PW'(x3) * $signed(PW'(K_COS));
    p3s = PW'(x3) * $signed(PW'(K_SIN));
    c1v = WW'(x1) + WW'(p1c >>> K_FRAC);
    s1v = WW'(p1s >>> K_FRAC);
    c3v = WW'(x3) + WW'(p3c >>> K_FRAC);
    s3v = WW'(p3s >>> K_FRAC);
    a_v = WW'(x0) + WW'(x2);
    b_v = WW'(x0) - WW'(x2);
    c_v = s1v - c3v;
    d_v = c1v + s3v;
    o0 = a_v + d_v;
    o1 = b_v + c_v;
    o2 = b_v - c_v;
    o3 = a_v - d_v;
  end

  assign out_o = {OW'(o3), OW'(o2), OW'(o1), OW'(o0)};
endmodule

// File: rtl/dqr_recon.sv
module dqr_recon #(
  parameter int IW = dqr_pkg::COEF_W + 4,
  parameter int CW = dqr_pkg::COEF_W,
  parameter int PW = dqr_pkg::PIX_W,
  parameter int N  = dqr_pkg::DIM
) (
  input  logic [N*IW-1:0] row_i,
  input  logic [N*PW-1:0] pred_i,
  output logic [N*PW-1:0] pix_o
);
  import dqr_pkg::*;
  localparam int SW = CW + 2;
  localparam logic signed [SW-1:0] PMAX = SW'((1 << PW) - 1);

  for (genvar j = 0; j < N; j++) begin : g_px
    logic signed [IW-1:0] v, sh;
    logic signed [CW-1:0] res;
    logic signed [SW-1:0] tot;
    logic [PW-1:0]        px;
    always_comb begin
      v   = $signed(row_i[j*IW +: IW]);
      sh  = (v + IW'(RND_ADD)) >>> RND_SH;
      res = CW'(sh);
      tot = SW'(res) + $signed({{(SW-PW){1'b0}}, pred_i[j*PW +: PW]});
      if (tot < 0)         px = '0;
      else if (tot > PMAX) px = '1;
      else                 px = PW'(tot);
    end
    assign pix_o[j*PW +: PW] = px;
  end
endmodule

// File: rtl/dqr_top.sv
module dqr_top #(
  parameter int CW = dqr_pkg::COEF_W,
  parameter int PW = dqr_pkg::PIX_W,
  parameter int N  = dqr_pkg::DIM
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [N*N*CW-1:0] coef_i,
  input  logic [N*N*CW-1:0] dqf_i,
  input  logic [N*N*PW-1:0] pred_i,
  output logic              busy_o,
  output logic              pix_valid_o,
  output logic [N*PW-1:0]   pix_o,
  output logic              done_o,
  output logic [N*N*CW-1:0] coef_buf_o
);
  import dqr_pkg::*;
  localparam int NE  = N * N;
  localparam int RW  = CW + 4;
  localparam int RBW = (N > 1) ? $clog2(N) : 1;
  localparam logic [RBW-1:0] LAST_ROW = RBW'(N - 1);

  dqr_state_t       st_q, st_n;
  logic [RBW-1:0]   row_q, row_n;
  logic [NE*CW-1:0] buf_q, buf_n, dqf_q, dqf_n, tmp_q, tmp_n;
  logic [NE*PW-1:0] pred_q, pred_n;
  logic [N*PW-1:0]  pix_n;
  logic             vld_n, done_n;

  logic [NE*CW-1:0] deq_w, col_w;
  logic [N*RW-1:0]  rowt_w;
  logic [N*PW-1:0]  recon_w;

  dqr_dequant #(.CW(CW), .NE(NE)) u_deq (
    .coef_i(buf_q), .dqf_i(dqf_q), .prod_o(deq_w)
  );

  // first pass: one butterfly per column, outputs wrapped to CW bits
  for (genvar c = 0; c < N; c++) begin : g_col
    logic [4*CW-1:0] cin, cout;
    assign cin = {buf_q[(c+3*N)*CW +: CW], buf_q[(c+2*N)*CW +: CW],
                  buf_q[(c+N)*CW +: CW],   buf_q[c*CW +: CW]};
    dqr_bfly #(.W(CW), .OW(CW)) u_cb (.in_i(cin), .out_o(cout));
    for (genvar r = 0; r < N; r++) begin : g_wr
      assign col_w[(r*N+c)*CW +: CW] = cout[r*CW +: CW];
    end
  end

  // second pass: one row per cycle
  dqr_bfly #(.W(CW), .OW(RW)) u_rb (
    .in_i(tmp_q[row_q*N*CW +: N*CW]), .out_o(rowt_w)
  );

  dqr_recon #(.IW(RW), .CW(CW), .PW(PW), .N(N)) u_rec (
    .row_i(rowt_w), .pred_i(pred_q[row_q*N*PW +: N*PW]), .pix_o(recon_w)
  );

  always_comb begin
    st_n   = st_q;
    row_n  = row_q;
    buf_n  = buf_q;
    dqf_n  = dqf_q;
    pred_n = pred_q;
    tmp_n  = tmp_q;
    pix_n  = pix_o;
    vld_n  = 1'b0;
    done_n = 1'b0;
    unique case (st_q)
      S_IDLE: if (start_i) begin
        st_n   = S_DEQ;
        buf_n  = coef_i;
        dqf_n  = dqf_i;
        pred_n = pred_i;
      end
      S_DEQ: begin
        buf_n = deq_w;
        st_n  = S_COL;
      end
      S_COL: begin
        tmp_n = col_w;
        row_n = '0;
        st_n  = S_ROW;
      end
      S_ROW: begin
        pix_n = recon_w;
        vld_n = 1'b1;
        row_n = row_q + 1'b1;
        if (row_q == LAST_ROW) begin
          done_n = 1'b1;
          buf_n  = '0;
          st_n   = S_IDLE;
        end
      end
      default: st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= S_IDLE;
      row_q       <= '0;
      buf_q       <= '0;
      dqf_q       <= '0;
      pred_q      <= '0;
      tmp_q       <= '0;
      pix_o       <= '0;
      pix_valid_o <= 1'b0;
      done_o      <= 1'b0;
    end else begin
      st_q        <= st_n;
      row_q       <= row_n;
      buf_q       <= buf_n;
      dqf_q       <= dqf_n;
      pred_q      <= pred_n;
      tmp_q       <= tmp_n;
      pix_o       <= pix_n;
      pix_valid_o <= vld_n;
      done_o      <= done_n;
    end
  end

  assign busy_o     = (st_q != S_IDLE);
  assign coef_buf_o = buf_q;

  // R2: an accepted start makes the unit busy on the next cycle
  a_r2_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> busy_o);
  // R11: a start while busy never reloads the sequence
  a_r11_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> (st_q != S_DEQ));
  // R10: done accompanies a valid row and lasts one cycle
  a_r10_done_with_row: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> pix_valid_o);
  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R9: store is cleared once the block is finished
  a_r9_store_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (coef_buf_o == '0));
  // R2: rows only stream while the sequencer is in or just leaving its row phase
  a_r2_valid_in_rows: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid_o |-> ($past(st_q) == S_ROW));
endmodule

// File: tb/sim_dqr_top.sv
module sim_dqr_top;
  localparam int CLK_P = 10;
  localparam int WD_LIMIT = 100000;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start_i = 1'b0;
  logic [255:0] coef_i = '0;
  logic [255:0] dqf_i = '0;
  logic [127:0] pred_i = '0;
  logic         busy_o, pix_valid_o, done_o;
  logic [31:0]  pix_o;
  logic [255:0] coef_buf_o;

  dqr_top u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .coef_i(coef_i), .dqf_i(dqf_i),
    .pred_i(pred_i), .busy_o(busy_o), .pix_valid_o(pix_valid_o), .pix_o(pix_o),
    .done_o(done_o), .coef_buf_o(coef_buf_o)
  );

  always #(CLK_P/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic [31:0] expq[$];
  int row_idx = 0;

  int cf[16];
  int fq[16];
  int pr[16];

  task automatic chk(input bit ok, input string tag, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == WD_LIMIT) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  // reference arithmetic (R4, R6)
  function automatic int fc(input int x);
    return x + ((x * 20091) >>> 16);
  endfunction
  function automatic int fs(input int x);
    return (x * 35468) >>> 16;
  endfunction
  function automatic void bfly(input int i0, input int i1, input int i2, input int i3,
                               output int o0, output int o1, output int o2, output int o3);
    int a, b, c, d;
    a = i0 + i2; b = i0 - i2;
    c = fs(i1) - fc(i3); d = fc(i1) + fs(i3);
    o0 = a + d; o1 = b + c; o2 = b - c; o3 = a - d;
  endfunction

  // monitor: pops expected rows (R2, R5..R8, R9, R10, R11)
  always @(negedge clk) begin
    if (rst_n && pix_valid_o) begin
      if (expq.size() == 0) begin
        chk(1'b0, "R11 unexpected row", 256'(pix_o), 256'(0));
      end else begin
        logic [31:0] e;
        e = expq.pop_front();
        chk(pix_o == e, $sformatf("R8 row%0d pixels", row_idx), 256'(pix_o), 256'(e));
        chk(done_o == (row_idx == 3), "R10 done on last row", 256'(done_o), 256'(row_idx == 3));
        if (done_o) chk(coef_buf_o == '0, "R9 store cleared", coef_buf_o, 256'(0));
        row_idx = (row_idx + 1) % 4;
      end
    end
  end

  task automatic run_block(input bit mid_start);
    logic [255:0] deqv;
    short_calc: begin end
    begin
      int dq[16];
      int t[16];
      int o[4];
      for (int k = 0; k < 16; k++) begin
        dq[k] = int'(signed'(16'(cf[k] * fq[k])));       // R3
        deqv[k*16 +: 16] = 16'(dq[k]);
      end
      for (int c = 0; c < 4; c++) begin                  // R5 columns
        bfly(dq[c], dq[c+4], dq[c+8], dq[c+12], o[0], o[1], o[2], o[3]);
        for (int r = 0; r < 4; r++) t[r*4+c] = int'(signed'(16'(o[r])));
      end
      for (int r = 0; r < 4; r++) begin                  // R5 rows, R7, R8
        logic [31:0] rowv;
        bfly(t[r*4], t[r*4+1], t[r*4+2], t[r*4+3], o[0], o[1], o[2], o[3]);
        for (int j = 0; j < 4; j++) begin
          int res, p;
          res = int'(signed'(16'((o[j] + 4) >>> 3)));
          p = pr[r*4+j] + res;
          if (p < 0) p = 0;
          if (p > 255) p = 255;
          rowv[j*8 +: 8] = 8'(p);
        end
        expq.push_back(rowv);
      end
    end
    for (int k = 0; k < 16; k++) begin
      coef_i[k*16 +: 16] = 16'(cf[k]);
      dqf_i[k*16 +: 16]  = 16'(fq[k]);
      pred_i[k*8 +: 8]   = 8'(pr[k]);
    end
    chk(!busy_o, "R2 idle before start", 256'(busy_o), 256'(0));
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o, "R2 busy after start", 256'(busy_o), 256'(1));
    @(negedge clk);
    chk(coef_buf_o == deqv, "R3 dequantized store", coef_buf_o, deqv);
    if (mid_start) begin
      coef_i = ~coef_i;
      pred_i = ~pred_i;
      start_i = 1'b1;
    end
    @(negedge clk);
    start_i = 1'b0;
    chk(!pix_valid_o, "R2 no row before latency", 256'(pix_valid_o), 256'(0));
    @(negedge clk);
    chk(pix_valid_o, "R2 row0 latency", 256'(pix_valid_o), 256'(1));
    for (int w = 0; w < 20 && (expq.size() != 0 || busy_o); w++) @(negedge clk);
    repeat (6) @(negedge clk);
    chk(expq.size() == 0 && !busy_o, "R11 block completed once", 256'(expq.size()), 256'(0));
    chk(coef_buf_o == '0, "R9 store stays cleared", coef_buf_o, 256'(0));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy_o && !pix_valid_o && !done_o, "R1 reset outputs",
        256'({busy_o, pix_valid_o, done_o}), 256'(0));
    rst_n = 1'b1;
    @(negedge clk);

    // zero coefficients: predictor passes through (R8)
    for (int k = 0; k < 16; k++) begin cf[k] = 0; fq[k] = 7; pr[k] = k * 13; end
    run_block(1'b0);

    // DC-only block (R4..R7)
    for (int k = 0; k < 16; k++) begin cf[k] = 0; fq[k] = 4; pr[k] = 100; end
    cf[0] = 25;
    run_block(1'b0);

    // single AC terms exercise both constants (R4, R6)
    for (int k = 0; k < 16; k++) begin cf[k] = 0; fq[k] = 10; pr[k] = 128; end
    cf[1] = 9; cf[4] = -7; cf[5] = 11; cf[15] = -3;
    run_block(1'b0);

    // saturation at 255 and at 0 (R8)
    for (int k = 0; k < 16; k++) begin cf[k] = 0; fq[k] = 4; pr[k] = 250; end
    cf[0] = 2000;
    run_block(1'b0);
    for (int k = 0; k < 16; k++) begin cf[k] = 0; fq[k] = 4; pr[k] = 5; end
    cf[0] = -2000;
    run_block(1'b0);

    // product wrap in dequantization and first pass (R3, R5)
    for (int k = 0; k < 16; k++) begin
      cf[k] = int'($urandom_range(0, 65535)) - 32768;
      fq[k] = int'($urandom_range(0, 65535));
      pr[k] = int'($urandom_range(0, 255));
    end
    run_block(1'b0);

    // start while busy is ignored (R11)
    for (int k = 0; k < 16; k++) begin
      cf[k] = int'($urandom_range(0, 600)) - 300;
      fq[k] = int'($urandom_range(1, 150));
      pr[k] = int'($urandom_range(0, 255));
    end
    run_block(1'b1);

    // random blocks
    for (int n = 0; n < 24; n++) begin
      for (int k = 0; k < 16; k++) begin
        cf[k] = int'($urandom_range(0, 400)) - 200;
        fq[k] = int'($urandom_range(1, 160));
        pr[k] = int'($urandom_range(0, 255));
      end
      run_block(n % 5 == 2);
    end

    summary();
    $finish;
  end
endmodule